// File: doc/BRIEF.md
# Ping-Pong Buffer Address Sequencer

This block feeds a streaming transmitter from two alternating memory buffers. Software programs a start address for each buffer, one shared length in bytes, four interrupt enables and a run bit. While running, the block issues word read addresses one at a time. It starts at the first buffer and steps through it word by word. When a buffer has been fully fetched, it moves on to the other buffer.

Each time a buffer is exhausted, the block sets a sticky empty flag for that buffer. It also latches the value of a free-running cycle counter as that buffer's departure time. The block counts the words it holds in a small prefetch store. If the transmitter asks for a word while that store is empty, the block raises a bandwidth-error flag. If a buffer runs out while the other buffer has still not been handed back by software, the block raises an underrun flag and carries on with the other buffer anyway.

Software acknowledges each flag by writing a one to it. The single interrupt line is a level signal. It is high while any flag is set whose enable bit is also set.

Top module: `pingpong_dma_ctrl`

## Requirements
- R1: After reset the run bit, all enables, all flags, both timestamps and the active-buffer index are zero, and both `fetch_req` and `irq` are low.
- R2: Register word addresses are: 0 control, 1 acknowledge, 2 first start address, 3 second start address, 4 length in bytes, 5 status, 6 first timestamp, 7 second timestamp. The control register holds the run bit at bit 0 and interrupt enables at bits 4:1. The first start address, second start address, length and control registers read back what was last written, and the acknowledge register reads as zero.
- R3: While running, `fetch_addr` equals the active buffer's start address plus four times the word offset. The offset starts at 0 on buffer 0 and advances by one for each accepted fetch (`fetch_req` and `fetch_ack` both high).
- R4: A buffer spans max(1, floor(length/64)) × 16 words. The accepted fetch of its last word resets the offset to zero, toggles the active index (status bit 4), and sets that buffer's empty flag (status bit 0 for buffer 0, bit 1 for buffer 1).
- R5: A cycle counter clears on reset and then increments on every clock. On the edge that exhausts a buffer, that buffer's timestamp register takes the counter value held before that edge.
- R6: If a buffer is exhausted while the other buffer's empty flag is still set, the underrun flag (status bit 3) is set, and the switch to the other buffer still happens.
- R7: `fetch_req` is high only while running and while fewer than PF_DEPTH words are held. The held count rises on each accepted fetch and falls on each `word_take` when it is non-zero.
- R8: A `word_take` while running with zero words held sets the bandwidth-error flag (status bit 2).
- R9: Flags are sticky. Writing 1 to a bit of the acknowledge register (same bit positions as status bits 3:0) clears that flag at the next edge. Writing 0 leaves it unchanged. A set event in the same cycle as the acknowledge wins.
- R10: `irq` is high exactly when some flag is set whose enable is set; enable bit k+1 of control gates status bit k.
- R11: One edge after the run bit reads 0, the active index and offset return to buffer 0 start and the held count to zero; flags and timestamps are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write word address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register read word address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| fetch_req | output | 1 | A word read may be issued |
| fetch_addr | output | ADDR_W | Byte address of the next word to read |
| fetch_ack | input | 1 | Fetch accepted this cycle |
| word_take | input | 1 | Transmitter consumes one held word |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with PF_DEPTH = 2 and SIZE_W = 12. The shallow prefetch store makes fetch back-pressure and the empty-store error occur within a few cycles of random consumption. The narrow length field keeps buffers between 16 and a few hundred words. This lets many buffer switches, unacknowledged double drains, the minimum-length clamp and mid-buffer length changes all happen within a few thousand cycles.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_ACK    = 3'd1,
        RA_BASE0  = 3'd2,
        RA_BASE1  = 3'd3,
        RA_LEN    = 3'd4,
        RA_STATUS = 3'd5,
        RA_STAMP0 = 3'd6,
        RA_STAMP1 = 3'd7
    } ppdma_reg_e;

    // Bit 0 is buffer 0 empty, bit 3 is underrun.
    typedef struct packed {
        logic udr;
        logic bwe;
        logic emp1;
        logic emp0;
    } ppdma_flags_t;

    typedef struct packed {
        logic [3:0] irq_en;
        logic       run;
    } ppdma_ctrl_t;

    localparam int BLOCK_SHIFT = 6;
    localparam int WORDS_PER_BLOCK_SHIFT = 4;

    function automatic logic [31:0] span_words(input logic [31:0] len_bytes);
        logic [31:0] blocks;
        blocks = len_bytes >> BLOCK_SHIFT;
        if (blocks == 32'd0) blocks = 32'd1;
        return blocks << WORDS_PER_BLOCK_SHIFT;
    endfunction

endpackage

// File: rtl/ppdma_regs.sv
module ppdma_regs
    import ppdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  ppdma_flags_t      set_ev,
    output ppdma_ctrl_t       ctrl,
    output logic [ADDR_W-1:0] base0,
    output logic [ADDR_W-1:0] base1,
    output logic [SIZE_W-1:0] len,
    output ppdma_flags_t      flags,
    output logic              irq
);

    localparam int NFLAG = $bits(ppdma_flags_t);

    logic [NFLAG-1:0] ack_bits;

    always_comb begin
        ack_bits = '0;
        if (wr_en && (ppdma_reg_e'(wr_addr) == RA_ACK))
            ack_bits = wr_data[NFLAG-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            base0 <= '0;
            base1 <= '0;
            len   <= '0;
            flags <= '0;
        end else begin
            flags <= ppdma_flags_t'(set_ev | (flags & ~ack_bits));
            if (wr_en) begin
                case (ppdma_reg_e'(wr_addr))
                    RA_CTRL:  ctrl  <= ppdma_ctrl_t'(wr_data[$bits(ppdma_ctrl_t)-1:0]);
                    RA_BASE0: base0 <= wr_data[ADDR_W-1:0];
                    RA_BASE1: base1 <= wr_data[ADDR_W-1:0];
                    RA_LEN:   len   <= wr_data[SIZE_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    assign irq = |(flags & ctrl.irq_en);

endmodule

// File: rtl/ppdma_addr_gen.sv
module ppdma_addr_gen
    import ppdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [ADDR_W-1:0] base0,
    input  logic [ADDR_W-1:0] base1,
    input  logic [SIZE_W-1:0] len,
    input  logic              fire,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              active,
    output logic              drain
);

    localparam int OFF_W = SIZE_W - 2;

    logic [OFF_W-1:0] offset;
    logic [31:0]      last_idx;
    logic [ADDR_W-1:0] base_sel;

    assign last_idx   = span_words(32'(len)) - 32'd1;
    assign drain      = fire && (32'(offset) >= last_idx);
    assign base_sel   = active ? base1 : base0;
    assign fetch_addr = base_sel + ADDR_W'({offset, 2'b00});

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            offset <= '0;
            active <= 1'b0;
        end else if (fire) begin
            if (drain) begin
                offset <= '0;
                active <= ~active;
            end else begin
                offset <= offset + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ppdma_prefetch.sv
module ppdma_prefetch #(
    parameter int PF_DEPTH = 4,
    localparam int LVL_W = $clog2(PF_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             fetch_ack,
    input  logic             take,
    output logic             fetch_req,
    output logic             fire,
    output logic             starve,
    output logic [LVL_W-1:0] level
);

    logic taken;

    assign fetch_req = run && (level < LVL_W'(PF_DEPTH));
    assign fire      = fetch_req && fetch_ack;
    assign taken     = take && (level != '0);
    assign starve    = run && take && (level == '0);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            level <= '0;
        end else begin
            case ({fire, taken})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/ppdma_timestamp.sv
module ppdma_timestamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            drain,
    input  logic            drain_buf,
    output logic [TS_W-1:0] now,
    output logic [TS_W-1:0] stamp0,
    output logic [TS_W-1:0] stamp1
);

    always_ff @(posedge clk) begin
        if (rst) begin
            now    <= '0;
            stamp0 <= '0;
            stamp1 <= '0;
        end else begin
            now <= now + 1'b1;
            if (drain && !drain_buf) stamp0 <= now;
            if (drain &&  drain_buf) stamp1 <= now;
        end
    end

endmodule

// File: rtl/pingpong_dma_ctrl.sv
module pingpong_dma_ctrl
    import ppdma_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SIZE_W   = 16,
    parameter int PF_DEPTH = 4,
    parameter int TS_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_addr,
    input  logic [31:0]       reg_wr_data,
    input  logic [2:0]        reg_rd_addr,
    output logic [31:0]       reg_rd_data,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_ack,
    input  logic              word_take,
    output logic              irq
);

    localparam int LVL_W = $clog2(PF_DEPTH + 1);

    ppdma_ctrl_t       ctrl_q;
    ppdma_flags_t      flags_q;
    ppdma_flags_t      set_ev;
    logic [ADDR_W-1:0] base0_q;
    logic [ADDR_W-1:0] base1_q;
    logic [SIZE_W-1:0] len_q;
    logic              active;
    logic              drain;
    logic              fire;
    logic              starve;
    logic [LVL_W-1:0]  level;
    logic [TS_W-1:0]   now;
    logic [TS_W-1:0]   stamp0;
    logic [TS_W-1:0]   stamp1;

    always_comb begin
        set_ev      = '0;
        set_ev.emp0 = drain && !active;
        set_ev.emp1 = drain &&  active;
        set_ev.bwe  = starve;
        set_ev.udr  = drain && (active ? flags_q.emp0 : flags_q.emp1);
    end

    ppdma_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .set_ev  (set_ev),
        .ctrl    (ctrl_q),
        .base0   (base0_q),
        .base1   (base1_q),
        .len     (len_q),
        .flags   (flags_q),
        .irq     (irq)
    );

    ppdma_prefetch #(.PF_DEPTH(PF_DEPTH)) u_pf (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl_q.run),
        .fetch_ack (fetch_ack),
        .take      (word_take),
        .fetch_req (fetch_req),
        .fire      (fire),
        .starve    (starve),
        .level     (level)
    );

    ppdma_addr_gen #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ag (
        .clk        (clk),
        .rst        (rst),
        .run        (ctrl_q.run),
        .base0      (base0_q),
        .base1      (base1_q),
        .len        (len_q),
        .fire       (fire),
        .fetch_addr (fetch_addr),
        .active     (active),
        .drain      (drain)
    );

    ppdma_timestamp #(.TS_W(TS_W)) u_ts (
        .clk       (clk),
        .rst       (rst),
        .drain     (drain),
        .drain_buf (active),
        .now       (now),
        .stamp0    (stamp0),
        .stamp1    (stamp1)
    );

    always_comb begin
        reg_rd_data = '0;
        case (ppdma_reg_e'(reg_rd_addr))
            RA_CTRL:   reg_rd_data = 32'(ctrl_q);
            RA_ACK:    reg_rd_data = '0;
            RA_BASE0:  reg_rd_data = 32'(base0_q);
            RA_BASE1:  reg_rd_data = 32'(base1_q);
            RA_LEN:    reg_rd_data = 32'(len_q);
            RA_STATUS: reg_rd_data = 32'({active, flags_q});
            RA_STAMP0: reg_rd_data = 32'(stamp0);
            RA_STAMP1: reg_rd_data = 32'(stamp1);
            default:   reg_rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ppdma_chk.sv
module ppdma_chk #(
    parameter int PF_DEPTH = 4,
    parameter int TS_W     = 32,
    localparam int LVL_W   = $clog2(PF_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr_en,
    input logic [2:0]       reg_wr_addr,
    input logic [31:0]      reg_wr_data,
    input logic             fetch_req,
    input logic             irq,
    input logic [3:0]       flags,
    input logic [4:0]       ctrl,
    input logic             active,
    input logic             drain,
    input logic [LVL_W-1:0] level,
    input logic [TS_W-1:0]  now,
    input logic [TS_W-1:0]  stamp0,
    input logic [TS_W-1:0]  stamp1
);

    logic ack0;
    assign ack0 = reg_wr_en && (reg_wr_addr == 3'd1) && reg_wr_data[0];

    p_level_bound_r7: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(PF_DEPTH));

    p_idle_no_req_r11: assert property (@(posedge clk) disable iff (rst)
        !ctrl[0] |-> !fetch_req);

    p_idle_home_r11: assert property (@(posedge clk) disable iff (rst)
        !ctrl[0] |=> !active);

    p_drain_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        drain |=> (active != $past(active)));

    p_stamp0_r5: assert property (@(posedge clk) disable iff (rst)
        (drain && !active) |=> (stamp0 == $past(now)));

    p_stamp1_r5: assert property (@(posedge clk) disable iff (rst)
        (drain && active) |=> (stamp1 == $past(now)));

    p_underrun_r6: assert property (@(posedge clk) disable iff (rst)
        (drain && active && flags[0]) |=> flags[3]);

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (flags[0] && !ack0) |=> flags[0]);

    p_ack_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (ack0 && !(drain && !active)) |=> !flags[0]);

    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (flags == 4'd0) |-> !irq);

endmodule

bind pingpong_dma_ctrl ppdma_chk #(.PF_DEPTH(PF_DEPTH), .TS_W(TS_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .reg_wr_data (reg_wr_data),
    .fetch_req   (fetch_req),
    .irq         (irq),
    .flags       (flags_q),
    .ctrl        (ctrl_q),
    .active      (active),
    .drain       (drain),
    .level       (level),
    .now         (now),
    .stamp0      (stamp0),
    .stamp1      (stamp1)
);

// File: tb/tb_pingpong_dma_ctrl.sv
`timescale 1ns/1ps
module tb_pingpong_dma_ctrl;

    localparam int ADDR_W = 32;
    localparam int SIZE_W = 12;
    localparam int PFD    = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [2:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        fetch_ack = 1'b0;
    logic        word_take = 1'b0;
    logic        irq;

    always #2.5 clk = ~clk;

    pingpong_dma_ctrl #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .PF_DEPTH(PFD), .TS_W(32)) dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
        .word_take(word_take), .irq(irq)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference model state
    logic        m_run = 0;
    logic [3:0]  m_ien = 0;
    logic [31:0] m_base0 = 0, m_base1 = 0;
    logic [SIZE_W-1:0] m_len = 0;
    logic [3:0]  m_flags = 0;
    logic        m_act = 0;
    int          m_off = 0;
    int          m_lvl = 0;
    logic [31:0] m_cnt = 0, m_st0 = 0, m_st1 = 0;

    function automatic int span(input logic [SIZE_W-1:0] l);
        int b = int'(l) >> 6;
        if (b == 0) b = 1;
        return b * 16;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd_addr = a;
        #0.15;
        d = reg_rd_data;
    endtask

    task automatic check_all();
        logic [31:0] d;
        chk("R7 fetch_req", 32'(fetch_req), 32'(m_run && (m_lvl < PFD)));
        chk("R3 fetch_addr", fetch_addr, (m_act ? m_base1 : m_base0) + 32'(m_off * 4));
        chk("R10 irq", 32'(irq), 32'(|(m_flags & m_ien)));
        rd(3'd0, d); chk("R2 control", d, {27'd0, m_ien, m_run});
        rd(3'd1, d); chk("R2 ack reads zero", d, 32'd0);
        rd(3'd2, d); chk("R2 start0", d, m_base0);
        rd(3'd3, d); chk("R2 start1", d, m_base1);
        rd(3'd4, d); chk("R2 length", d, 32'(m_len));
        rd(3'd5, d);
        chk("R4 active index", 32'(d[4]), 32'(m_act));
        chk("R9 empty flags", 32'(d[1:0]), 32'(m_flags[1:0]));
        chk("R8 bandwidth flag", 32'(d[2]), 32'(m_flags[2]));
        chk("R6 underrun flag", 32'(d[3]), 32'(m_flags[3]));
        rd(3'd6, d); chk("R5 stamp0", d, m_st0);
        rd(3'd7, d); chk("R5 stamp1", d, m_st1);
    endtask

    // One clock: drive at negedge, advance model, check at next negedge.
    task automatic cyc(input logic wr, input logic [2:0] wa, input logic [31:0] wd,
                       input logic tk, input logic fa);
        logic req, fire, drain, bwe, udr;
        logic [3:0] ack, setv;
        int last;
        reg_wr_en = wr; reg_wr_addr = wa; reg_wr_data = wd;
        word_take = tk; fetch_ack = fa;
        req   = m_run && (m_lvl < PFD);
        fire  = req && fa;
        last  = span(m_len) - 1;
        drain = fire && (m_off >= last);
        bwe   = m_run && tk && (m_lvl == 0);
        udr   = drain && (m_act ? m_flags[0] : m_flags[1]);
        ack   = (wr && wa == 3'd1) ? wd[3:0] : 4'd0;
        setv  = {udr, bwe, drain && m_act, drain && !m_act};
        @(posedge clk);
        m_flags = setv | (m_flags & ~ack);
        if (drain) begin
            if (m_act) m_st1 = m_cnt; else m_st0 = m_cnt;
        end
        m_cnt = m_cnt + 1;
        if (!m_run) begin
            m_lvl = 0; m_act = 0; m_off = 0;
        end else begin
            m_lvl = m_lvl + (fire ? 1 : 0) - ((tk && m_lvl > 0) ? 1 : 0);
            if (fire) begin
                if (drain) begin m_off = 0; m_act = ~m_act; end
                else m_off = m_off + 1;
            end
        end
        if (wr) begin
            case (wa)
                3'd0: begin m_run = wd[0]; m_ien = wd[4:1]; end
                3'd2: m_base0 = wd;
                3'd3: m_base1 = wd;
                3'd4: m_len = wd[SIZE_W-1:0];
                default: ;
            endcase
        end
        @(negedge clk);
        reg_wr_en = 1'b0;
        check_all();
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic run_n(input int n, input logic tk, input logic fa);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 32'd0, tk, fa);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 fetch_req", 32'(fetch_req), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        rd(3'd5, d); chk("R1 status", d, 32'd0);
        rd(3'd0, d); chk("R1 control", d, 32'd0);
        rd(3'd6, d); chk("R1 stamp0", d, 32'd0);
        rd(3'd7, d); chk("R1 stamp1", d, 32'd0);
        check_all();

        // R2 programming, R3/R4 minimum-length buffers, R6 underrun with no acks
        wreg(3'd2, 32'h0000_1000);
        wreg(3'd3, 32'h0000_8000);
        wreg(3'd4, 32'd64);
        wreg(3'd0, 32'h1F);
        run_n(40, 1'b1, 1'b1);
        // R9 acknowledge all, then length 10 clamps to 16 words (R4)
        wreg(3'd1, 32'hF);
        wreg(3'd4, 32'd10);
        run_n(40, 1'b1, 1'b1);
        // R11 disable mid-buffer, flags kept, then re-enable
        wreg(3'd4, 32'd130);
        run_n(10, 1'b1, 1'b1);
        wreg(3'd0, 32'h1E);
        run_n(2, 1'b1, 1'b1);
        rd(3'd5, d);
        chk("R11 back to buffer 0", 32'(d[4]), 32'd0);
        chk("R11 flags kept", 32'(d[3:0]), 32'(m_flags));
        chk("R11 no request", 32'(fetch_req), 32'd0);
        wreg(3'd0, 32'h1F);
        // R8 starvation: consume without accepting fetches
        run_n(3, 1'b1, 1'b0);
        run_n(6, 1'b0, 1'b1);
        wreg(3'd1, 32'hF);
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom_range(0, 99));
            logic tk = ($urandom_range(0, 3) != 0);
            logic fa = ($urandom_range(0, 3) != 0);
            if (r < 6)       cyc(1'b1, 3'd1, 32'($urandom_range(0, 15)), tk, fa);
            else if (r < 7)  cyc(1'b1, 3'd0, {27'd0, 4'($urandom_range(0, 15)), 1'b1}, tk, fa);
            else if (r == 7) cyc(1'b1, 3'd0, 32'h0, tk, fa);
            else if (r == 8) cyc(1'b1, 3'd4, 32'($urandom_range(0, 400)), tk, fa);
            else if (r == 9) cyc(1'b1, 3'd2, {16'd0, 16'($urandom) & 16'hFFFC}, tk, fa);
            else             cyc(1'b0, 3'd0, 32'd0, tk, fa);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule